// File: doc/BRIEF.md
# Serial Command Frame Receiver with Zero-Sum Check

This block takes a fixed-length command frame from a three-wire serial link made of a bit clock, a data line and a latch strobe. All three wires are brought into the system clock domain through two-flop synchronizers, and their edges are detected there. The rising edge of the latch strobe starts a new frame. While the strobe is high, each rising edge of the bit clock shifts one data bit into a frame buffer.

When the latch strobe falls, the block adds up every byte of the buffer modulo 256. A frame is accepted only if exactly a full frame of bits arrived and the sum is zero. An accepted frame is copied to the output registers. A rejected frame leaves the last accepted frame in place.

A single pulse-enable output tells the downstream pulse generator whether it may run during the coming latch period. This output is cleared at every latch rise. At the latch fall it is raised only for an accepted frame whose pulse-count byte is non-zero.

Top module: `sfr_rx`

## Requirements
- R1: After reset, `frameOut`, `sumOk` and `pulseEn` are all zero.
- R2: Within each byte the bits arrive least significant bit first, and the data line is sampled on the rising edge of the bit clock. The n-th bit after a latch rise (n counted from 0) lands in `frameOut[n]`, so byte k, bit j sits at position 8k+j.
- R3: `sumOk` changes only at a latch falling edge. It then becomes 1 exactly when at least 104 bits were received and the modulo-256 sum of the 13 bytes is 00h.
- R4: Bits after the 104th within one latch period are discarded, and the bit counter never exceeds 104.
- R5: A frame with fewer than 104 bits is rejected (`sumOk` = 0), whatever its partial sum is.
- R6: `frameOut` changes only at a latch fall that accepts a frame. A rejected frame leaves it unchanged.
- R7: `pulseEn` goes low after every latch rising edge and stays low until the next latch fall.
- R8: At a latch fall, `pulseEn` becomes 1 only if the frame is accepted and byte 0 (the pulse-count field, `frameOut[7:0]`) is non-zero. `pulseEn` is never high while `sumOk` is low.
- R9: While bits are being shifted in, before the latch fall, `frameOut` keeps the previously accepted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial bit clock, asynchronous to clk |
| sdata | input | 1 | Serial data line, asynchronous to clk |
| latch | input | 1 | Frame strobe: the rise starts a frame, the fall commits it |
| frameOut | output | 104 | Last accepted frame; byte k at bits [8k+7:8k] |
| sumOk | output | 1 | Integrity result of the most recent latch fall |
| pulseEn | output | 1 | Gate that allows the downstream pulse output |

## Verification
The assertions check the following on every cycle:
- `sumOk` and `frameOut` hold still except on a commit strobe.
- `pulseEn` drops after a latch rise, and it never stands high without `sumOk`.
- A short frame always yields a rejection.
- The bit counter stays bounded, and no shift is taken once the frame is full.

The bench scenarios are the only way to show that the bit order and byte placement are right. They are also the only way to show that the modulo-256 sum is computed correctly across a sweep of pulse-count values and byte patterns, and that over-long frames keep exactly their first 104 bits.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  // Strobes from control to datapath, one system-clock cycle wide
  typedef struct packed {
    logic shiftBit;   // take the synchronized data bit into the buffer
    logic latchRise;  // new frame starts: clear the pulse gate
    logic commit;     // latch fell: evaluate and publish
  } sfrStrobes_t;

endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-2:0], din[g]};
    end
    assign dout[g] = pipe[STAGES-1];
  end

endmodule

// File: rtl/sfr_ctrl.sv
module sfr_ctrl
  import sfr_pkg::*;
#(
  parameter int FRAME_BITS = 104,
  parameter int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclkS,
  input  logic             latchS,
  output sfrStrobes_t      strobes,
  output logic [CNT_W-1:0] bitCnt,
  output logic             frameFull
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);

  logic sclkPrev, latchPrev;
  logic sclkRise, latchRise, latchFall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclkPrev  <= 1'b0;
      latchPrev <= 1'b0;
    end else begin
      sclkPrev  <= sclkS;
      latchPrev <= latchS;
    end
  end

  assign sclkRise  = sclkS & ~sclkPrev;
  assign latchRise = latchS & ~latchPrev;
  assign latchFall = ~latchS & latchPrev;
  assign frameFull = (bitCnt == FULL_CNT);

  // A latch rise wins over a coincident bit-clock rise
  always_comb begin
    strobes.shiftBit  = sclkRise && !latchRise && (bitCnt < FULL_CNT);
    strobes.latchRise = latchRise;
    strobes.commit    = latchFall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                bitCnt <= '0;
    else if (latchRise)        bitCnt <= '0;
    else if (strobes.shiftBit) bitCnt <= bitCnt + 1'b1;
  end

endmodule

// File: rtl/sfr_datapath.sv
module sfr_datapath
  import sfr_pkg::*;
#(
  parameter int FRAME_BYTES = 13,
  parameter int BYTE_W      = 8,
  parameter int COUNT_BYTE  = 0,
  localparam int TOTAL_BITS = FRAME_BYTES * BYTE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  sfrStrobes_t           strobes,
  input  logic                  sdataS,
  input  logic                  frameFull,
  output logic [TOTAL_BITS-1:0] frameOut,
  output logic                  sumOk,
  output logic                  pulseEn
);

  logic [TOTAL_BITS-1:0] shiftBuf;
  logic [BYTE_W-1:0]     runSum;
  logic                  frameGood;
  logic                  countNonZero;

  // Shift right from the top: after a full frame the first bit sits at bit 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                shiftBuf <= '0;
    else if (strobes.shiftBit) shiftBuf <= {sdataS, shiftBuf[TOTAL_BITS-1:1]};
  end

  always_comb begin
    runSum = '0;
    for (int i = 0; i < FRAME_BYTES; i++)
      runSum = runSum + shiftBuf[i*BYTE_W +: BYTE_W];
  end

  assign frameGood    = frameFull && (runSum == '0);
  assign countNonZero = |shiftBuf[COUNT_BYTE*BYTE_W +: BYTE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frameOut <= '0;
      sumOk    <= 1'b0;
      pulseEn  <= 1'b0;
    end else if (strobes.latchRise) begin
      pulseEn <= 1'b0;
    end else if (strobes.commit) begin
      sumOk   <= frameGood;
      pulseEn <= frameGood && countNonZero;
      if (frameGood) frameOut <= shiftBuf;
    end
  end

endmodule

// File: rtl/sfr_rx.sv
module sfr_rx
  import sfr_pkg::*;
#(
  parameter int FRAME_BYTES = 13,
  parameter int BYTE_W      = 8,
  parameter int COUNT_BYTE  = 0,
  parameter int SYNC_STAGES = 2,
  localparam int FRAME_BITS = FRAME_BYTES * BYTE_W,
  localparam int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic                  sdata,
  input  logic                  latch,
  output logic [FRAME_BITS-1:0] frameOut,
  output logic                  sumOk,
  output logic                  pulseEn
);

  logic [2:0]       syncOut;
  sfrStrobes_t      strobes;
  logic [CNT_W-1:0] bitCnt;
  logic             frameFull;

  sfr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({latch, sdata, sclk}),
    .dout (syncOut)
  );

  sfr_ctrl #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclkS    (syncOut[0]),
    .latchS   (syncOut[2]),
    .strobes  (strobes),
    .bitCnt   (bitCnt),
    .frameFull(frameFull)
  );

  sfr_datapath #(
    .FRAME_BYTES(FRAME_BYTES),
    .BYTE_W     (BYTE_W),
    .COUNT_BYTE (COUNT_BYTE)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .sdataS   (syncOut[1]),
    .frameFull(frameFull),
    .frameOut (frameOut),
    .sumOk    (sumOk),
    .pulseEn  (pulseEn)
  );

endmodule

// File: rtl/sfr_rx_chk.sv
module sfr_rx_chk
  import sfr_pkg::*;
#(
  parameter int FRAME_BITS = 104,
  parameter int CNT_W      = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input sfrStrobes_t           strobes,
  input logic [CNT_W-1:0]      bitCnt,
  input logic [FRAME_BITS-1:0] frameOut,
  input logic                  sumOk,
  input logic                  pulseEn
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bitCnt <= FULL_CNT);

  assert_no_shift_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.shiftBit |-> bitCnt < FULL_CNT);

  assert_ok_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.commit |=> $stable(sumOk));

  assert_short_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.commit && bitCnt != FULL_CNT) |=> !sumOk);

  assert_frame_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.commit |=> $stable(frameOut));

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.latchRise |=> !pulseEn);

  assert_flag_needs_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pulseEn |-> sumOk);

  assert_flag_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulseEn) |-> $past(strobes.commit));

endmodule

bind sfr_rx sfr_rx_chk #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .strobes (strobes),
  .bitCnt  (bitCnt),
  .frameOut(frameOut),
  .sumOk   (sumOk),
  .pulseEn (pulseEn)
);

// File: tb/sfr_rx_tb.sv
module sfr_rx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NBYTES     = 13;
  localparam int NBITS      = NBYTES * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic sdata = 1'b0;
  logic latch = 1'b0;
  logic [NBITS-1:0] frameOut;
  logic sumOk, pulseEn;

  int compared = 0;
  int mismatched = 0;

  logic [7:0]       txBytes [0:15];
  logic [NBITS-1:0] expFrame = '0;
  logic             expOk = 1'b0;
  logic             expEn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sfr_rx dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .latch(latch),
    .frameOut(frameOut), .sumOk(sumOk), .pulseEn(pulseEn)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    sdata = b;
    sclk  = 1'b0;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (2) @(negedge clk);
    sclk = 1'b0;
  endtask

  // nBytes bytes are sent, LSB first; the model decides acceptance itself
  task automatic sendFrame(input int nBytes, input string tag);
    logic [7:0]       s;
    logic [NBITS-1:0] vec;
    logic             good;
    latch = 1'b1;
    repeat (6) @(negedge clk);
    chk({"R7 pulseEn after latch rise ", tag}, 128'(pulseEn), 128'(0));
    for (int k = 0; k < nBytes; k++)
      for (int j = 0; j < 8; j++) sendBit(txBytes[k][j]);
    repeat (4) @(negedge clk);
    chk({"R9 frameOut during shift ", tag}, 128'(frameOut), 128'(expFrame));
    s = 8'h00;
    vec = '0;
    for (int k = 0; k < NBYTES; k++) begin
      s = s + txBytes[k];
      vec[k*8 +: 8] = txBytes[k];
    end
    good  = (nBytes >= NBYTES) && (s == 8'h00);
    expOk = good;
    expEn = good && (txBytes[0] != 8'h00);
    if (good) expFrame = vec;
    latch = 1'b0;
    repeat (8) @(negedge clk);
    chk({"R3 sumOk ", tag}, 128'(sumOk), 128'(expOk));
    chk({"R2/R6 frameOut ", tag}, 128'(frameOut), 128'(expFrame));
    chk({"R8 pulseEn ", tag}, 128'(pulseEn), 128'(expEn));
  endtask

  task automatic sealLast(input int last);
    logic [7:0] s;
    s = 8'h00;
    for (int k = 0; k < last; k++) s = s + txBytes[k];
    txBytes[last] = 8'h00 - s;
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int k = 0; k < 16; k++) txBytes[k] = 8'h00;
    repeat (4) @(negedge clk);
    chk("R1 reset frameOut", 128'(frameOut), 128'(0));
    chk("R1 reset sumOk", 128'(sumOk), 128'(0));
    chk("R1 reset pulseEn", 128'(pulseEn), 128'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3 R8: pulse-count sweep over valid frames
    for (int v = 0; v < 256; v += 5) begin
      txBytes[0] = 8'(v);
      for (int k = 1; k < 12; k++) txBytes[k] = 8'(v * 13 + k * 29 + 7);
      sealLast(12);
      sendFrame(NBYTES, "sweep");
    end

    // R3 R6: corrupted checksum is rejected and the old frame stays
    txBytes[5] = txBytes[5] ^ 8'h10;
    sendFrame(NBYTES, "bad sum");

    // R5: 12 bytes summing to zero are still too short
    for (int k = 0; k < 11; k++) txBytes[k] = 8'(k * 17 + 3);
    sealLast(11);
    txBytes[12] = 8'h00;
    sendFrame(12, "short");

    // R5: no bits at all
    sendFrame(0, "empty");

    // R4: valid frame followed by an extra byte
    for (int k = 0; k < 12; k++) txBytes[k] = 8'(k * 41 + 9);
    sealLast(12);
    txBytes[13] = 8'hA5;
    sendFrame(14, "long R4");

    // R8: all-zero frame is valid but carries no pulses
    for (int k = 0; k < NBYTES; k++) txBytes[k] = 8'h00;
    sendFrame(NBYTES, "zero count");

    // R8: max count with varied payload
    txBytes[0] = 8'hFF;
    for (int k = 1; k < 12; k++) txBytes[k] = 8'(8'hFF - k);
    sealLast(12);
    sendFrame(NBYTES, "max count");

    finishRun();
  end

endmodule